// File: doc/BRIEF.md
# Sequential Sprite Line Renderer with Overlap Detection

This block draws the sprites of one display line into an external line buffer, using a single pixel engine that handles the sprites one after another. Parallel per-sprite shifters are not used. The producer feeds sprites through a valid/ready queue, in order from lowest to highest priority. Each entry carries a horizontal start position, a 16-bit pattern row, a width select (8 or 16 pixels) and a colour. The engine walks the pattern one pixel at a time and writes the opaque pixels through a simple write port. Because the sprites are drawn in priority order, the highest-priority sprite is drawn last and wins every pixel it covers.

Next to the line buffer the engine keeps one occupancy bit per pixel position. For every set pattern bit it reads this bit first and then writes it. When the bit was already set, two sprites overlap on that pixel. This costs a read cycle before each write cycle. Sprites whose colour code is zero are invisible, but they still mark occupancy and still count for overlap detection. At the start of each line the whole occupancy memory is cleared.

Overlap and the externally detected too-many-sprites condition are first held in pending registers. They reach the CPU-visible status bits only on the end-of-line strobe. A CPU status read clears both status bits. A one-cycle done pulse tells the display side that the line buffer is complete.

Top module: `sprite_line_engine`

## Requirements
- R1: Sprites are accepted one at a time on cycles where spr_valid and spr_ready are both high. spr_ready is high only while the engine waits for the next sprite of a line that has started. A line of at least 32 sprites is fully rendered.
- R2: Sprites are drawn in arrival order. Where two sprites cover the same pixel, the colour of the later one remains in the line buffer.
- R3: Pixel i of a sprite (i counted from 0) sits at x+i and is taken from pattern bit 15-i. With spr_wide=1 the sprite is 16 pixels wide. With spr_wide=0 it is 8 pixels wide and only bits 15..8 are used. Pattern bits that are 0 produce no write.
- R4: Colour code 0 is transparent. Such a sprite makes no line-buffer write, but its set pattern bits still mark occupancy and take part in overlap detection.
- R5: A set pattern bit that lands on a position already marked by an earlier sprite of the same line sets the pending overlap flag.
- R6: A line_start pulse in idle clears every occupancy bit and both pending flags before the first sprite is drawn, so sprites of an earlier line never cause an overlap.
- R7: Pixels at positions of LINE_W or more are dropped. They make no write and mark no occupancy, so they never wrap onto the left side of the line.
- R8: The status bits change to the pending values only on a line_end pulse (status_coinc for overlap, status_fifth for fifth_in). Before that pulse they keep their old values.
- R9: A status_rd pulse clears status_coinc and status_fifth on the next edge. A line_end in the same cycle takes precedence.
- R10: done is high for exactly one cycle after the last pixel of the sprite marked spr_last has been processed, once per line.
- R11: A fifth_in pulse during a line sets the pending fifth-sprite flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Begin a new line: clear occupancy and pending flags |
| line_end | input | 1 | Publish the pending flags into the status bits |
| fifth_in | input | 1 | Too-many-sprites event from the evaluation stage |
| spr_valid | input | 1 | Sprite queue entry valid |
| spr_ready | output | 1 | Engine can take a sprite |
| spr_x | input | XW | Horizontal start position |
| spr_pat | input | 16 | Pattern row, MSB is the leftmost pixel |
| spr_wide | input | 1 | 1 selects 16 pixels, 0 selects 8 |
| spr_color | input | COL_W | Colour code, 0 is transparent |
| spr_last | input | 1 | Last sprite of the line |
| lb_we | output | 1 | Line-buffer write enable |
| lb_addr | output | XW | Line-buffer write position |
| lb_color | output | COL_W | Line-buffer write colour |
| done | output | 1 | Line rendering finished (one-cycle pulse) |
| status_rd | input | 1 | CPU status read strobe |
| status_coinc | output | 1 | Published overlap status bit |
| status_fifth | output | 1 | Published fifth-sprite status bit |

## Verification
The bench builds the engine with LINE_W=64 and COL_W=4. The narrow line keeps the clear pass short. It also lets a 16-pixel sprite near the right edge cross the boundary, and 32 one-pixel sprites fit side by side on one line. With these values, right-edge clipping, the no-wrap property of the occupancy memory, and a full 32-sprite line can all be exercised in a few thousand cycles. The line-buffer contents and the flags are compared against a model in the bench that applies the priority, transparency and overlap rules.

// File: rtl/sprite_line_engine.sv
module sprite_line_engine #(
  parameter int LINE_W = 256,
  parameter int COL_W  = 4,
  localparam int XW    = $clog2(LINE_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             line_end,
  input  logic             fifth_in,
  input  logic             spr_valid,
  output logic             spr_ready,
  input  logic [XW-1:0]    spr_x,
  input  logic [15:0]      spr_pat,
  input  logic             spr_wide,
  input  logic [COL_W-1:0] spr_color,
  input  logic             spr_last,
  output logic             lb_we,
  output logic [XW-1:0]    lb_addr,
  output logic [COL_W-1:0] lb_color,
  output logic             done,
  input  logic             status_rd,
  output logic             status_coinc,
  output logic             status_fifth
);
  typedef enum logic [2:0] {S_IDLE, S_CLR, S_FETCH, S_RD, S_WR, S_FIN} st_t;
  st_t state;

  logic             occ [LINE_W];
  logic             occ_q;
  logic [XW-1:0]    clr_idx;
  logic [XW-1:0]    x_q;
  logic [XW-1:0]    pos_q;
  logic [15:0]      pat_q;
  logic             wide_q, last_q;
  logic [COL_W-1:0] col_q;
  logic [3:0]       pix;
  logic [XW:0]      pos;
  logic             draw, adv, last_pix;
  logic             coinc_p, fifth_p;

  assign pos       = {1'b0, x_q} + (XW+1)'(pix);
  assign draw      = pat_q[4'd15 - pix] && (pos < (XW+1)'(LINE_W));
  assign last_pix  = wide_q ? (pix == 4'd15) : (pix == 4'd7);
  assign adv       = (state == S_RD && !draw) || state == S_WR;
  assign spr_ready = state == S_FETCH;
  assign lb_we     = state == S_WR && col_q != '0;
  assign lb_addr   = pos_q;
  assign lb_color  = col_q;
  assign done      = state == S_FIN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      clr_idx <= '0;
      x_q     <= '0;
      pos_q   <= '0;
      pat_q   <= '0;
      wide_q  <= 1'b0;
      last_q  <= 1'b0;
      col_q   <= '0;
      pix     <= '0;
    end else begin
      case (state)
        S_IDLE:  if (line_start) begin
                   state   <= S_CLR;
                   clr_idx <= '0;
                 end
        S_CLR:   begin
                   clr_idx <= clr_idx + 1'b1;
                   if (clr_idx == XW'(LINE_W-1)) state <= S_FETCH;
                 end
        S_FETCH: if (spr_valid) begin
                   x_q    <= spr_x;
                   pat_q  <= spr_pat;
                   wide_q <= spr_wide;
                   col_q  <= spr_color;
                   last_q <= spr_last;
                   pix    <= '0;
                   state  <= S_RD;
                 end
        S_RD:    if (draw) begin
                   pos_q <= pos[XW-1:0];
                   state <= S_WR;
                 end
        S_FIN:   state <= S_IDLE;
        default: ;
      endcase
      if (adv) begin
        if (last_pix) state <= last_q ? S_FIN : S_FETCH;
        else begin
          pix   <= pix + 1'b1;
          state <= S_RD;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_CLR) occ[clr_idx] <= 1'b0;
    if (state == S_WR)  occ[pos_q]   <= 1'b1;
    if (state == S_RD)  occ_q        <= occ[pos[XW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coinc_p      <= 1'b0;
      fifth_p      <= 1'b0;
      status_coinc <= 1'b0;
      status_fifth <= 1'b0;
    end else begin
      if (state == S_IDLE && line_start) coinc_p <= 1'b0;
      else if (state == S_WR && occ_q)   coinc_p <= 1'b1;
      if (fifth_in)                           fifth_p <= 1'b1;
      else if (state == S_IDLE && line_start) fifth_p <= 1'b0;
      if (line_end) begin
        status_coinc <= status_coinc | coinc_p;
        status_fifth <= status_fifth | fifth_p;
      end else if (status_rd) begin
        status_coinc <= 1'b0;
        status_fifth <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sprite_line_engine_chk.sv
module sprite_line_engine_chk #(
  parameter int LINE_W = 256,
  parameter int COL_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_end,
  input logic             status_rd,
  input logic             spr_ready,
  input logic             lb_we,
  input logic [COL_W-1:0] lb_color,
  input logic             done,
  input logic             status_coinc,
  input logic             status_fifth
);
  a_r4_no_transparent_write: assert property (@(posedge clk) disable iff (!rst_n)
    lb_we |-> lb_color != '0);
  a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_no_accept_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
    lb_we |-> !spr_ready);
  a_r9_read_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !line_end) |=> (!status_coinc && !status_fifth));
  a_r8_coinc_rises_at_line_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_coinc) |-> $past(line_end));
  a_r8_fifth_rises_at_line_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_fifth) |-> $past(line_end));
endmodule

bind sprite_line_engine sprite_line_engine_chk #(.LINE_W(LINE_W), .COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .line_end(line_end), .status_rd(status_rd),
  .spr_ready(spr_ready), .lb_we(lb_we), .lb_color(lb_color), .done(done),
  .status_coinc(status_coinc), .status_fifth(status_fifth));

// File: tb/sprite_line_engine_tb_top.sv
module sprite_line_engine_tb_top;
  localparam int LW = 64;
  localparam int XW = 6;

  logic clk = 0, rst_n = 0;
  logic line_start = 0, line_end = 0, fifth_in = 0, spr_valid = 0;
  logic spr_ready, spr_wide = 0, spr_last = 0;
  logic [XW-1:0] spr_x = '0;
  logic [15:0] spr_pat = '0;
  logic [3:0] spr_color = '0;
  logic lb_we, done, status_rd = 0, status_coinc, status_fifth;
  logic [XW-1:0] lb_addr;
  logic [3:0] lb_color;

  always #5 clk = ~clk;

  sprite_line_engine #(.LINE_W(LW), .COL_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_end(line_end),
    .fifth_in(fifth_in), .spr_valid(spr_valid), .spr_ready(spr_ready),
    .spr_x(spr_x), .spr_pat(spr_pat), .spr_wide(spr_wide), .spr_color(spr_color),
    .spr_last(spr_last), .lb_we(lb_we), .lb_addr(lb_addr), .lb_color(lb_color),
    .done(done), .status_rd(status_rd), .status_coinc(status_coinc),
    .status_fifth(status_fifth));

  int checks = 0, fails = 0, cycles = 0, done_cnt = 0, wr_cnt = 0;
  int got_lb [LW];
  int sx [40]; int sp [40]; int sw [40]; int sc [40];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (done) done_cnt++;
    if (lb_we) begin got_lb[lb_addr] = int'(lb_color); wr_cnt++; end
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_line(int n, bit fifth, bit both, string req);
    int exp_lb [LW]; bit mocc [LW]; bit ecoinc = 0; int ewr = 0; int t;
    for (int p = 0; p < LW; p++) begin exp_lb[p] = -1; mocc[p] = 0; got_lb[p] = -1; end
    for (int k = 0; k < n; k++)
      for (int i = 0; i < (sw[k] ? 16 : 8); i++)
        if (sp[k][15-i] && sx[k] + i < LW) begin
          if (mocc[sx[k]+i]) ecoinc = 1;
          mocc[sx[k]+i] = 1;
          if (sc[k] != 0) begin exp_lb[sx[k]+i] = sc[k]; ewr++; end
        end
    done_cnt = 0; wr_cnt = 0;
    @(posedge clk); #1 line_start = 1; fifth_in = fifth;
    @(posedge clk); #1 line_start = 0; fifth_in = 0;
    for (int k = 0; k < n; k++) begin
      spr_valid = 1; spr_x = XW'(sx[k]); spr_pat = 16'(sp[k]);
      spr_wide = sw[k][0]; spr_color = 4'(sc[k]); spr_last = (k == n-1);
      do @(negedge clk); while (!spr_ready);
      @(posedge clk); #1 spr_valid = 0;
    end
    t = 0;
    while (done_cnt == 0 && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    check(done_cnt == 1, {req, " R10 done pulses"}, done_cnt, 1);
    check(wr_cnt == ewr, {req, " R3 write count"}, wr_cnt, ewr);
    for (int p = 0; p < LW; p++)
      if (got_lb[p] != exp_lb[p])
        check(0, {req, " R2 pixel colour"}, got_lb[p], exp_lb[p]);
    check(!status_coinc && !status_fifth, {req, " R8 status held before line end"},
          int'(status_coinc), 0);
    @(posedge clk); #1 line_end = 1; status_rd = both;
    @(posedge clk); #1 line_end = 0; status_rd = 0;
    @(negedge clk);
    check(status_coinc == ecoinc, {req, " R5 overlap status"}, int'(status_coinc), int'(ecoinc));
    check(status_fifth == fifth, {req, " R11 fifth status"}, int'(status_fifth), int'(fifth));
    @(posedge clk); #1 status_rd = 1;
    @(posedge clk); #1 status_rd = 0;
    @(negedge clk);
    check(!status_coinc && !status_fifth, {req, " R9 read clears"}, int'(status_coinc), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!spr_ready && !lb_we && !done, "R1 reset outputs idle", int'(spr_ready), 0);
    check(!status_coinc && !status_fifth, "R8 reset status", int'(status_coinc), 0);
  endtask

  task automatic t_single;
    sx[0] = 5; sp[0] = 'hA5FF; sw[0] = 0; sc[0] = 3;
    run_line(1, 0, 0, "R3 narrow single");
    sx[0] = 20; sp[0] = 'h8001; sw[0] = 1; sc[0] = 9;
    run_line(1, 0, 0, "R3 wide single");
  endtask

  task automatic t_overlap;
    sx[0] = 10; sp[0] = 'hFF00; sw[0] = 0; sc[0] = 2;
    sx[1] = 14; sp[1] = 'hFF00; sw[1] = 0; sc[1] = 7;
    run_line(2, 0, 0, "R2 R5 overlap priority");
  endtask

  task automatic t_transparent;
    sx[0] = 30; sp[0] = 'hF000; sw[0] = 0; sc[0] = 6;
    sx[1] = 31; sp[1] = 'hC000; sw[1] = 0; sc[1] = 0;
    run_line(2, 0, 0, "R4 transparent overlap");
    sx[0] = 40; sp[0] = 'hF000; sw[0] = 0; sc[0] = 6;
    sx[1] = 44; sp[1] = 'h0F00; sw[1] = 1; sc[1] = 5;
    run_line(2, 0, 0, "R3 zero bits no overlap");
  endtask

  task automatic t_new_line;
    sx[0] = 12; sp[0] = 'hFF00; sw[0] = 0; sc[0] = 4;
    run_line(1, 0, 0, "R6 first line");
    sx[0] = 12; sp[0] = 'hFF00; sw[0] = 0; sc[0] = 8;
    run_line(1, 0, 0, "R6 occupancy cleared");
  endtask

  task automatic t_clip;
    sx[0] = 60; sp[0] = 'hFFFF; sw[0] = 1; sc[0] = 11;
    sx[1] = 2;  sp[1] = 'hFF00; sw[1] = 0; sc[1] = 12;
    run_line(2, 0, 0, "R7 right edge clip no wrap");
  endtask

  task automatic t_fifth;
    sx[0] = 0; sp[0] = 'h8000; sw[0] = 0; sc[0] = 1;
    run_line(1, 1, 0, "R11 fifth pending");
    sx[0] = 0; sp[0] = 'h8000; sw[0] = 0; sc[0] = 1;
    sx[1] = 0; sp[1] = 'h8000; sw[1] = 0; sc[1] = 2;
    run_line(2, 1, 1, "R9 line end beats read");
  endtask

  task automatic t_full;
    for (int k = 0; k < 32; k++) begin
      sx[k] = 2*k; sp[k] = 'h8000; sw[k] = k % 2; sc[k] = 1 + (k % 15);
    end
    run_line(32, 0, 0, "R1 thirty-two sprites");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_single();
    t_overlap();
    t_transparent();
    t_new_line();
    t_clip();
    t_fifth();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule